// File: doc/BRIEF.md
# Paged Switch Register Access Sequencer

This block turns one 32-bit access to a switch register into a short series of 16-bit management-bus transactions. An Ethernet switch that only exposes a 16-bit management interface reaches its wide registers through paging: a page value goes to a fixed page location, and the two 16-bit halves of the target register are then read or written at a pseudo-PHY address formed from the register offset.

A client presents one request: direction, model code, register offset and write data. The sequencer then issues the page write and the two half-word transactions to a management-bus master through a command pulse and response handshake. When the sequence ends it returns a one-cycle completion with the assembled read data or an error flag. The model code selects the page location. For one register it also reverses the order in which the two halves are written, because that register only acts on its contents when a given half arrives last.

Top module: `swreg_pager`

## Requirements
- R1: Each accepted request with a known model code first issues a write of `offset >> 9` (zero-extended to 16 bits). The write goes to PHY 0x1f, register 0x10 for model code 0, and to PHY 0x18, register 0x00 for model code 1.
- R2: Both half-word transactions use PHY address `0x10 | offset[8:6]`. The low half is at register `(offset >> 1) & 0x1e` and the high half is at that register ORed with 1.
- R3: A read fetches the low half, then the high half, with command data 0. It completes with `rdata = {high, low}` and no error.
- R4: A write normally sends `wdata[31:16]` to the high half first and then `wdata[15:0]` to the low half. It completes with `rdata` 0.
- R5: For model code 0 and offset exactly 0x98, a write sends the low half first and then the high half.
- R6: With model code 1, offset 0x98 keeps the normal high-first write order, and offsets other than 0x98 with model code 0 do as well.
- R7: A response with its error bit set ends the sequence at once. No further command is issued, and the block completes with the error flag set and `rdata` 0.
- R8: Model codes 2 and 3 are refused. The block completes with the error flag on the cycle after the request and issues no command.
- R9: `req_ready` is high only while no sequence is running. A request presented during a sequence is ignored and does not change the commands that follow.
- R10: Completion and each command are single-cycle pulses. A successful sequence issues exactly three commands and one completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_model | input | 2 | Model code: 0 or 1 known, others refused |
| req_offset | input | OFS_W | Switch register byte offset |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Error flag, valid with `done` |
| rdata | output | 32 | Assembled read data, valid with `done` |
| mdio_cmd_valid | output | 1 | One-cycle command pulse to the bus master |
| mdio_cmd_write | output | 1 | Command is a write |
| mdio_cmd_phy | output | 5 | Command PHY address |
| mdio_cmd_reg | output | 5 | Command register number |
| mdio_cmd_wdata | output | 16 | Command write data |
| mdio_rsp_valid | input | 1 | One-cycle response from the bus master |
| mdio_rsp_err | input | 1 | Response reports a failed transaction |
| mdio_rsp_rdata | input | 16 | Response read data |

## Verification
A corrupted step counter or latched order flag shows up on the very next command pulse. It appears as a wrong PHY or register field, or as a half-word sent in the wrong order, so it is caught on the first command that follows it. A state machine stuck outside idle shows as `req_ready` staying low and as a missing or extra completion pulse within one cycle of the last response. A lost error path shows as a command issued after a failing response.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam logic [1:0] MODEL_A = 2'd0;
    localparam logic [1:0] MODEL_B = 2'd1;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic logic model_known(input logic [1:0] m);
        return (m == MODEL_A) || (m == MODEL_B);
    endfunction

endpackage

// File: rtl/swreg_addr_map.sv
module swreg_addr_map
    import swreg_pkg::*;
#(
    parameter int          OFS_W     = 18,
    parameter logic [17:0] ORDER_OFS = 18'h00098
) (
    input  logic [1:0]       model,
    input  logic             wr,
    input  logic [OFS_W-1:0] ofs,
    output logic [4:0]       page_phy,
    output logic [4:0]       page_reg,
    output logic [15:0]      page_val,
    output logic [4:0]       half_phy,
    output logic [4:0]       base_reg,
    output logic             low_first
);
    localparam int PAGE_W = OFS_W - 9;

    // Page value: offset bits above 8, zero-extended or truncated to 16 bits.
    generate
        if (PAGE_W >= 16) begin : g_page_trunc
            assign page_val = ofs[9 +: 16];
        end else begin : g_page_ext
            assign page_val = {{(16 - PAGE_W){1'b0}}, ofs[OFS_W-1:9]};
        end
    endgenerate

    assign page_phy  = (model == MODEL_A) ? 5'h1f : 5'h18;
    assign page_reg  = (model == MODEL_A) ? 5'h10 : 5'h00;
    assign half_phy  = {2'b10, ofs[8:6]};
    assign base_reg  = {ofs[5:2], 1'b0};
    // Reads always go low first; the one ordered register on model A is written low first.
    assign low_first = !wr || ((model == MODEL_A) && (ofs == ORDER_OFS[OFS_W-1:0]));

endmodule

// File: rtl/swreg_step_mux.sv
module swreg_step_mux
    import swreg_pkg::*;
(
    input  logic [1:0]  step,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic [4:0]  page_phy,
    input  logic [4:0]  page_reg,
    input  logic [15:0] page_val,
    input  logic [4:0]  half_phy,
    input  logic [4:0]  base_reg,
    input  logic        low_first,
    output mdio_cmd_t   cmd,
    output logic        cur_hi
);
    always_comb begin
        cur_hi = (step == 2'd1) ? !low_first : low_first;
        if (step == 2'd0) begin
            cmd.wr   = 1'b1;
            cmd.phy  = page_phy;
            cmd.regn = page_reg;
            cmd.data = page_val;
        end else begin
            cmd.wr   = wr;
            cmd.phy  = half_phy;
            cmd.regn = {base_reg[4:1], cur_hi};
            cmd.data = !wr ? 16'h0000 : (cur_hi ? wdata[31:16] : wdata[15:0]);
        end
    end
endmodule

// File: rtl/swreg_pager.sv
module swreg_pager
    import swreg_pkg::*;
#(
    parameter int          OFS_W     = 18,
    parameter logic [17:0] ORDER_OFS = 18'h00098
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_model,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [31:0]      req_wdata,
    output logic             req_ready,
    output logic             done,
    output logic             done_err,
    output logic [31:0]      rdata,
    output logic             mdio_cmd_valid,
    output logic             mdio_cmd_write,
    output logic [4:0]       mdio_cmd_phy,
    output logic [4:0]       mdio_cmd_reg,
    output logic [15:0]      mdio_cmd_wdata,
    input  logic             mdio_rsp_valid,
    input  logic             mdio_rsp_err,
    input  logic [15:0]      mdio_rsp_rdata
);
    localparam logic [1:0] LAST_STEP = 2'd2;

    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       step;
        logic             wr;
        logic [1:0]       model;
        logic [OFS_W-1:0] ofs;
        logic [31:0]      wdata;
        logic [15:0]      hbuf;
        logic             done;
        logic             err;
        logic [31:0]      rdata;
    } regs_t;

    regs_t q, d;

    logic [4:0]  page_phy, page_reg, half_phy, base_reg;
    logic [15:0] page_val;
    logic        low_first, cur_hi;
    mdio_cmd_t   cmd;

    swreg_addr_map #(.OFS_W(OFS_W), .ORDER_OFS(ORDER_OFS)) u_map (
        .model    (q.model),
        .wr       (q.wr),
        .ofs      (q.ofs),
        .page_phy (page_phy),
        .page_reg (page_reg),
        .page_val (page_val),
        .half_phy (half_phy),
        .base_reg (base_reg),
        .low_first(low_first)
    );

    swreg_step_mux u_mux (
        .step     (q.step),
        .wr       (q.wr),
        .wdata    (q.wdata),
        .page_phy (page_phy),
        .page_reg (page_reg),
        .page_val (page_val),
        .half_phy (half_phy),
        .base_reg (base_reg),
        .low_first(low_first),
        .cmd      (cmd),
        .cur_hi   (cur_hi)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!model_known(req_model)) begin
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                        d.rdata = 32'h0;
                    end else begin
                        d.st    = ST_ISSUE;
                        d.step  = 2'd0;
                        d.wr    = req_write;
                        d.model = req_model;
                        d.ofs   = req_offset;
                        d.wdata = req_wdata;
                    end
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (mdio_rsp_valid) begin
                    if (mdio_rsp_err) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                        d.rdata = 32'h0;
                    end else if (q.step == LAST_STEP) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.rdata = q.wr ? 32'h0 :
                                  (cur_hi ? {mdio_rsp_rdata, q.hbuf} : {q.hbuf, mdio_rsp_rdata});
                    end else begin
                        if (q.step == 2'd1) d.hbuf = mdio_rsp_rdata;
                        d.step = q.step + 2'd1;
                        d.st   = ST_ISSUE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready      = (q.st == ST_IDLE);
    assign done           = q.done;
    assign done_err       = q.err;
    assign rdata          = q.rdata;
    assign mdio_cmd_valid = (q.st == ST_ISSUE);
    assign mdio_cmd_write = cmd.wr;
    assign mdio_cmd_phy   = cmd.phy;
    assign mdio_cmd_reg   = cmd.regn;
    assign mdio_cmd_wdata = cmd.data;

    p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_cmd_valid |=> !mdio_cmd_valid);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> (done && rdata == 32'h0));

    p_abort_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && mdio_rsp_valid && mdio_rsp_err) |=> (done && done_err && !mdio_cmd_valid));

    p_bad_model_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !model_known(req_model)) |=> (done && done_err && req_ready));

    p_page_write_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && model_known(req_model)) |=> (mdio_cmd_valid && mdio_cmd_write));

endmodule

// File: tb/swreg_pager_tb_top.sv
module swreg_pager_tb_top;
    localparam int OFS_W = 18;
    localparam int VW    = 1 + 2 + OFS_W + 32 + 16 + 16 + 2;
    localparam int NVEC  = 13;

    // {write, model, offset, wdata, lo, hi, fail(0 none, 1 page, 2 first half, 3 second half)}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 18'h0010c, 32'h0,         16'h7fff, 16'h1800, 2'd0},
        {1'b1, 2'd0, 18'h00098, 32'hc8a51234,  16'h0,    16'h0,    2'd0},
        {1'b1, 2'd1, 18'h00098, 32'h0badf00d,  16'h0,    16'h0,    2'd0},
        {1'b1, 2'd0, 18'h00624, 32'h7f7f7f7f,  16'h0,    16'h0,    2'd0},
        {1'b0, 2'd1, 18'h3ffff, 32'h0,         16'haaaa, 16'h5555, 2'd0},
        {1'b1, 2'd0, 18'h00040, 32'h12345678,  16'h0,    16'h0,    2'd0},
        {1'b0, 2'd0, 18'h00098, 32'h0,         16'h0001, 16'h8000, 2'd0},
        {1'b1, 2'd0, 18'h00099, 32'hdeadbeef,  16'h0,    16'h0,    2'd0},
        {1'b0, 2'd0, 18'h0005c, 32'h0,         16'h1111, 16'h2222, 2'd2},
        {1'b1, 2'd1, 18'h00010, 32'h40000000,  16'h0,    16'h0,    2'd1},
        {1'b1, 2'd0, 18'h00098, 32'hffff0000,  16'h0,    16'h0,    2'd3},
        {1'b0, 2'd2, 18'h0010c, 32'h0,         16'h0,    16'h0,    2'd0},
        {1'b1, 2'd3, 18'h00098, 32'h55aa55aa,  16'h0,    16'h0,    2'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [1:0]       req_model = 2'd0;
    logic [OFS_W-1:0] req_offset = '0;
    logic [31:0]      req_wdata = '0;
    logic             req_ready, done, done_err;
    logic [31:0]      rdata;
    logic             mdio_cmd_valid, mdio_cmd_write;
    logic [4:0]       mdio_cmd_phy, mdio_cmd_reg;
    logic [15:0]      mdio_cmd_wdata;
    logic             mdio_rsp_valid = 1'b0;
    logic             mdio_rsp_err = 1'b0;
    logic [15:0]      mdio_rsp_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    swreg_pager #(.OFS_W(OFS_W)) dut_i (
        .clk, .rst_n, .req_valid, .req_write, .req_model, .req_offset, .req_wdata,
        .req_ready, .done, .done_err, .rdata,
        .mdio_cmd_valid, .mdio_cmd_write, .mdio_cmd_phy, .mdio_cmd_reg, .mdio_cmd_wdata,
        .mdio_rsp_valid, .mdio_rsp_err, .mdio_rsp_rdata
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected command {write, phy, reg, data} for command index 0..2
    function automatic logic [26:0] exp_cmd(input int idx, input logic wr, input logic [1:0] m,
                                            input logic [OFS_W-1:0] ofs, input logic [31:0] wd);
        logic       hi_first, is_hi;
        logic [4:0] base;
        logic [15:0] dat;
        logic [OFS_W-1:0] pg;
        if (idx == 0) begin
            pg = ofs >> 9;
            return {1'b1, (m == 2'd0) ? 5'h1f : 5'h18, (m == 2'd0) ? 5'h10 : 5'h00, pg[15:0]};
        end
        hi_first = wr && !(m == 2'd0 && ofs == 18'h00098);
        is_hi    = (idx == 1) ? hi_first : !hi_first;
        base     = 5'((ofs >> 1) & 18'h1e);
        dat      = !wr ? 16'h0 : (is_hi ? wd[31:16] : wd[15:0]);
        return {wr, 5'h10 | {2'b00, ofs[8:6]}, base | {4'b0, is_hi}, dat};
    endfunction

    task automatic run_vec(input logic [VW-1:0] v, input logic poke);
        logic             wr;
        logic [1:0]       m, fail;
        logic [OFS_W-1:0] ofs;
        logic [31:0]      wd;
        logic [15:0]      lo, hi;
        int               ncmd, nexp;
        logic             got_done, got_err;
        logic [31:0]      got_rd;
        logic [26:0]      got, expc;
        {wr, m, ofs, wd, lo, hi, fail} = v;
        ncmd = 0; got_done = 0; got_err = 0; got_rd = '0;
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready when idle", {63'b0, req_ready}, 64'd1);
        req_valid = 1'b1; req_write = wr; req_model = m; req_offset = ofs; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int g = 0; g < 100 && !got_done; g++) begin
            if (done) begin
                got_done = 1; got_err = done_err; got_rd = rdata;
            end else if (mdio_cmd_valid) begin
                got  = {mdio_cmd_write, mdio_cmd_phy, mdio_cmd_reg, mdio_cmd_wdata};
                expc = exp_cmd(ncmd, wr, m, ofs, wd);
                if (ncmd == 0)
                    check(got == expc, "R1 page write", {37'b0, got}, {37'b0, expc});
                else if (m == 2'd0 && ofs == 18'h00098 && wr)
                    check(got == expc, "R5 low-first write", {37'b0, got}, {37'b0, expc});
                else if (wr)
                    check(got == expc, "R4 R6 high-first write", {37'b0, got}, {37'b0, expc});
                else
                    check(got == expc, "R2 R3 read half", {37'b0, got}, {37'b0, expc});
                ncmd++;
                @(negedge clk);
                check(mdio_cmd_valid === 1'b0, "R10 command pulse", {63'b0, mdio_cmd_valid}, 64'd0);
                if (poke && ncmd == 1) begin
                    check(req_ready === 1'b0, "R9 busy not ready", {63'b0, req_ready}, 64'd0);
                    req_valid = 1'b1; req_write = ~wr; req_model = 2'd1; req_offset = 18'h3fe00; req_wdata = 32'h0;
                    @(negedge clk);
                    req_valid = 1'b0;
                end else begin
                    @(negedge clk);
                end
                mdio_rsp_valid = 1'b1;
                mdio_rsp_err   = (fail == 2'(ncmd));
                mdio_rsp_rdata = got[16] ? hi : lo;
                @(negedge clk);
                mdio_rsp_valid = 1'b0; mdio_rsp_err = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        nexp = !(m == 2'd0 || m == 2'd1) ? 0 : (fail != 2'd0 ? int'(fail) : 3);
        if (nexp == 0)
            check(ncmd == 0, "R8 no command for unknown model", 64'(ncmd), 64'(nexp));
        else if (fail != 2'd0)
            check(ncmd == nexp, "R7 abort stops commands", 64'(ncmd), 64'(nexp));
        else
            check(ncmd == nexp, "R10 three commands", 64'(ncmd), 64'(nexp));
        check(got_done, "R10 completion seen", {63'b0, got_done}, 64'd1);
        if (nexp == 0 || fail != 2'd0) begin
            check(got_err === 1'b1, "R7 R8 error flag", {63'b0, got_err}, 64'd1);
            check(got_rd == 32'h0, "R7 rdata zero on error", {32'b0, got_rd}, 64'd0);
        end else begin
            check(got_err === 1'b0, "R3 R4 no error", {63'b0, got_err}, 64'd0);
            check(got_rd == (wr ? 32'h0 : {hi, lo}), "R3 R4 rdata",
                  {32'b0, got_rd}, {32'b0, wr ? 32'h0 : {hi, lo}});
        end
        @(negedge clk);
        check(done === 1'b0, "R10 completion pulse", {63'b0, done}, 64'd0);
        check(mdio_cmd_valid === 1'b0, "R9 ignored request issues nothing", {63'b0, mdio_cmd_valid}, 64'd0);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && done === 1'b0 && mdio_cmd_valid === 1'b0, "R9 R10 reset state",
              {61'b0, req_ready, done, mdio_cmd_valid}, 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R9 idle after reset", {63'b0, req_ready}, 64'd1);
        for (int i = 0; i < NVEC; i++) run_vec(VEC[i], 1'b0);
        // Directed: request during a running sequence is ignored (R9)
        run_vec({1'b1, 2'd0, 18'h00098, 32'ha1b2c3d4, 16'h0, 16'h0, 2'd0}, 1'b1);
        run_vec({1'b0, 2'd1, 18'h001c6, 32'h0, 16'hbeef, 16'hcafe, 2'd0}, 1'b1);
        // Directed: back-to-back known and unknown models
        run_vec({1'b0, 2'd3, 18'h00000, 32'h0, 16'h0, 16'h0, 2'd0}, 1'b0);
        run_vec({1'b0, 2'd1, 18'h00000, 32'h0, 16'h1201, 16'h0000, 2'd0}, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule